// File: doc/BRIEF.md
# All-Bank Flexible Refresh Scheduler

This block decides, for one DRAM rank, when an all-bank refresh goes out. A timer tick advances a local notion of time, and a deadline register marks when the next refresh falls due. At each deadline the scheduler picks one of three courses. It can defer the refresh because some bank still has work. It can force the refresh once too many have been deferred. Or, while every bank stays idle, it can issue further refreshes ahead of time, banking credit against later intervals.

A signed credit counter records the balance. It rises by one per deferral, up to a postpone ceiling. It falls by one per early refresh, down to a negative pull-in floor. The block hands its requests to a timing checker: a request is raised, held unchanged, and counts as executed in the cycle the checker's ready is high. When the block forces a refresh, or precharges the rank for one, it raises a block signal that keeps the bank machines from taking new work until the refresh-all has gone out.

Top module: `rf_allbank_sched`

## Requirements
- R1: After reset the scheduler is in its regular state with zero credit, no request, block low and both done pulses low; the first deadline lies one refresh interval of ticks after reset.
- R2: In the regular state, when the deadline is reached with credit below the postpone ceiling and any bank not idle, no request is raised; credit rises by one and the deadline moves one interval later.
- R3: When the deadline is reached in the regular state with credit equal to the postpone ceiling, a request is raised whatever the banks are doing, and block goes high together with it; credit never exceeds the ceiling.
- R4: A request raised in the regular state is a precharge-all (cmd_kind = 0) if any bank's activated flag is set, and otherwise a refresh-all (cmd_kind = 1).
- R5: Acceptance of a precharge-all sets block and moves the scheduler to its precharged state, in which the only request it makes is a refresh-all; a forced refresh-all request also enters that state.
- R6: A request stays raised with the same kind until a cycle with chk_ready high; that cycle is the acceptance and pulses done_pre (precharge-all) or done_ref (refresh-all) for that cycle only.
- R7: Acceptance of a refresh-all enters the pulled-in state if the scheduler was not already there, and lowers credit by one if it was; reaching the pull-in floor (credit = minus the pull-in limit) returns the scheduler to regular and moves the deadline one interval later.
- R8: Acceptance of a refresh-all at a tick count t with t + refresh duration greater than or equal to the deadline plus one interval also returns the scheduler to regular and moves the deadline one interval later.
- R9: In the pulled-in state, with the deadline reached, any bank not idle returns the scheduler to regular without a request and moves the deadline one interval later; with every bank idle another refresh-all is requested.
- R10: Block falls in the cycle after a refresh-all is accepted and is otherwise held.
- R11: A postpone limit of zero makes every due refresh a forced one, and a pull-in limit of zero lets only one refresh-all go out per deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the tick count by one in this cycle |
| bank_idle | input | NUM_BANKS | Per bank, high when the bank machine has no pending work |
| bank_act | input | NUM_BANKS | Per bank, high when the bank holds an open row |
| chk_ready | input | 1 | Timing checker allows the requested command in this cycle |
| cmd_valid | output | 1 | A command request is raised |
| cmd_kind | output | 1 | 0 = precharge-all, 1 = refresh-all |
| block_banks | output | 1 | Bank machines must accept no new work |
| done_pre | output | 1 | A precharge-all is accepted in this cycle |
| done_ref | output | 1 | A refresh-all is accepted in this cycle |

## Verification
The hardest case to reach is the late-acceptance exit of R8. A forced refresh-all has to be held by the timing checker long enough that the tick count passes the deadline by more than an interval minus the refresh duration. Meanwhile the credit must sit away from the pull-in floor, so the floor does not end the run first. The stimulus gets there in three steps. Busy banks are held until credit reaches the ceiling. Then the banks are freed while chk_ready is held low for a long stretch across the forced deadline, and ready is released afterwards. A second instance with both limits at zero runs on the same inputs to cover R11.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    ST_REGULAR    = 2'd0,
    ST_PRECHARGED = 2'd1,
    ST_PULLEDIN   = 2'd2
  } rf_state_e;

  localparam logic KIND_PREA = 1'b0;
  localparam logic KIND_REFA = 1'b1;

  // Width of the signed credit counter: magnitude of the larger limit plus sign and margin.
  function automatic int credit_width(input int ceil_lim, input int floor_lim);
    int big;
    big = (ceil_lim > floor_lim) ? ceil_lim : floor_lim;
    return $clog2(big + 1) + 2;
  endfunction

endpackage

// File: rtl/rf_timebase.sv
module rf_timebase #(
  parameter int TIME_W       = 20,
  parameter int REF_INTERVAL = 20,
  parameter int REF_DURATION = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic advance,
  output logic due,
  output logic window_closed
);
  localparam logic [TIME_W-1:0] IVL   = TIME_W'(REF_INTERVAL);
  localparam logic [TIME_W:0]   IVL_X = (TIME_W+1)'(REF_INTERVAL);
  localparam logic [TIME_W:0]   DUR_X = (TIME_W+1)'(REF_DURATION);

  logic [TIME_W-1:0] now_q;
  logic [TIME_W-1:0] deadline_q;

  // Late check: does the refresh finishing now run past the following deadline?
  function automatic logic late_past_next(input logic [TIME_W-1:0] t, input logic [TIME_W-1:0] dl);
    return ({1'b0, t} + DUR_X) >= ({1'b0, dl} + IVL_X);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q      <= '0;
      deadline_q <= IVL;
    end else begin
      if (tick)    now_q      <= now_q + 1'b1;
      if (advance) deadline_q <= deadline_q + IVL;
    end
  end

  assign due           = (now_q >= deadline_q);
  assign window_closed = late_past_next(now_q, deadline_q);

  // A deadline only moves while it is due: every advance path is gated by the deadline.
  assert_advance_when_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> due);

endmodule

// File: rtl/rf_bank_summary.sv
module rf_bank_summary #(
  parameter int NUM_BANKS = 4
) (
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic [NUM_BANKS-1:0] bank_act,
  output logic                 any_busy,
  output logic                 any_open
);
  logic [NUM_BANKS:0] busy_chain;
  logic [NUM_BANKS:0] open_chain;

  assign busy_chain[0] = 1'b0;
  assign open_chain[0] = 1'b0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign busy_chain[b+1] = busy_chain[b] | ~bank_idle[b];
    assign open_chain[b+1] = open_chain[b] |  bank_act[b];
  end

  assign any_busy = busy_chain[NUM_BANKS];
  assign any_open = open_chain[NUM_BANKS];

endmodule

// File: rtl/rf_credit_counter.sv
module rf_credit_counter #(
  parameter int MAX_POSTPONE = 2,
  parameter int MAX_PULLIN   = 2,
  parameter int CW           = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic at_ceiling,
  output logic at_floor,
  output logic dec_reaches_floor
);
  localparam logic signed [CW-1:0] CEIL  = CW'(MAX_POSTPONE);
  localparam logic signed [CW-1:0] FLOOR = CW'(-MAX_PULLIN);
  localparam logic signed [CW-1:0] ONE   = CW'(1);

  logic signed [CW-1:0] credit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   credit_q <= '0;
    else if (inc) credit_q <= credit_q + ONE;
    else if (dec) credit_q <= credit_q - ONE;
  end

  assign at_ceiling        = (credit_q == CEIL);
  assign at_floor          = (credit_q == FLOOR);
  assign dec_reaches_floor = ((credit_q - ONE) == FLOOR);

  assert_credit_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_q <= CEIL) && (credit_q >= FLOOR));

  assert_no_postpone_past_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_ceiling);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

endmodule

// File: rtl/rf_allbank_sched.sv
module rf_allbank_sched
  import rf_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int MAX_POSTPONE = 2,
  parameter int MAX_PULLIN   = 2,
  parameter int REF_INTERVAL = 20,
  parameter int REF_DURATION = 6,
  parameter int TIME_W       = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic [NUM_BANKS-1:0] bank_act,
  input  logic                 chk_ready,
  output logic                 cmd_valid,
  output logic                 cmd_kind,
  output logic                 block_banks,
  output logic                 done_pre,
  output logic                 done_ref
);
  localparam int CW = credit_width(MAX_POSTPONE, MAX_PULLIN);

  rf_state_e state_q;
  logic      req_q;
  logic      kind_q;
  logic      block_q;

  logic due, window_closed;
  logic any_busy, any_open;
  logic at_ceiling, at_floor, dec_reaches_floor;

  // Named internal events.
  logic accept_ev, pre_accept_ev, ref_accept_ev;
  logic decide_ev, postpone_ev, pullin_exit_ev;
  logic forced_now, floor_hit, run_ends_ev, advance_ev, dec_ev;

  rf_timebase #(
    .TIME_W      (TIME_W),
    .REF_INTERVAL(REF_INTERVAL),
    .REF_DURATION(REF_DURATION)
  ) u_time (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .advance      (advance_ev),
    .due          (due),
    .window_closed(window_closed)
  );

  rf_bank_summary #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .bank_idle(bank_idle),
    .bank_act (bank_act),
    .any_busy (any_busy),
    .any_open (any_open)
  );

  rf_credit_counter #(
    .MAX_POSTPONE(MAX_POSTPONE),
    .MAX_PULLIN  (MAX_PULLIN),
    .CW          (CW)
  ) u_credit (
    .clk              (clk),
    .rst_n            (rst_n),
    .inc              (postpone_ev),
    .dec              (dec_ev),
    .at_ceiling       (at_ceiling),
    .at_floor         (at_floor),
    .dec_reaches_floor(dec_reaches_floor)
  );

  assign accept_ev      = req_q & chk_ready;
  assign pre_accept_ev  = accept_ev & (kind_q == KIND_PREA);
  assign ref_accept_ev  = accept_ev & (kind_q == KIND_REFA);
  assign decide_ev      = ~req_q & due;
  assign forced_now     = at_ceiling;
  assign postpone_ev    = decide_ev & (state_q == ST_REGULAR) & ~forced_now & any_busy;
  assign pullin_exit_ev = decide_ev & (state_q == ST_PULLEDIN) & any_busy;
  assign floor_hit      = (state_q == ST_PULLEDIN) ? dec_reaches_floor : at_floor;
  assign run_ends_ev    = ref_accept_ev & (floor_hit | window_closed);
  assign dec_ev         = ref_accept_ev & (state_q == ST_PULLEDIN);
  assign advance_ev     = postpone_ev | pullin_exit_ev | run_ends_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_REGULAR;
      req_q   <= 1'b0;
      kind_q  <= KIND_PREA;
      block_q <= 1'b0;
    end else if (req_q) begin
      if (chk_ready) begin
        req_q <= 1'b0;
        if (kind_q == KIND_PREA) begin
          block_q <= 1'b1;
          state_q <= ST_PRECHARGED;
        end else begin
          block_q <= 1'b0;
          state_q <= run_ends_ev ? ST_REGULAR : ST_PULLEDIN;
        end
      end
    end else if (due) begin
      unique case (state_q)
        ST_REGULAR: begin
          if (forced_now || !any_busy) begin
            req_q  <= 1'b1;
            kind_q <= any_open ? KIND_PREA : KIND_REFA;
            if (forced_now) begin
              block_q <= 1'b1;
              if (!any_open) state_q <= ST_PRECHARGED;
            end
          end
        end
        ST_PRECHARGED: begin
          req_q  <= 1'b1;
          kind_q <= KIND_REFA;
        end
        ST_PULLEDIN: begin
          if (any_busy) begin
            state_q <= ST_REGULAR;
          end else begin
            req_q  <= 1'b1;
            kind_q <= KIND_REFA;
          end
        end
        default: state_q <= ST_REGULAR;
      endcase
    end
  end

  assign cmd_valid   = req_q;
  assign cmd_kind    = kind_q;
  assign block_banks = block_q;
  assign done_pre    = pre_accept_ev;
  assign done_ref    = ref_accept_ev;

  // ---------------- assertions ----------------
  assert_request_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !chk_ready) |=> (cmd_valid && $stable(cmd_kind)));

  assert_precharged_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRECHARGED) |-> block_banks);

  assert_precharged_only_refa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && state_q == ST_PRECHARGED) |-> (cmd_kind == KIND_REFA));

  assert_postpone_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    postpone_ev |=> !cmd_valid);

  assert_forced_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_ev && state_q == ST_REGULAR && forced_now) |=> (cmd_valid && block_banks));

  assert_block_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_ref |=> !block_banks);

  assert_exit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pullin_exit_ev |=> (!cmd_valid && state_q == ST_REGULAR));

endmodule

// File: tb/tb_rf_allbank_sched.sv
module tb_ref_model #(
  parameter int NB   = 4,
  parameter int MPP  = 2,
  parameter int MPI  = 2,
  parameter int IVL  = 20,
  parameter int DUR  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NB-1:0] idle,
  input  logic [NB-1:0] act,
  input  logic          ready,
  output int            m_valid,
  output int            m_kind,
  output int            m_block,
  output int            m_event,
  output int            n_postpone,
  output int            n_forced,
  output int            n_prea,
  output int            n_floor,
  output int            n_late,
  output int            n_exit
);
  int now_t, due_t, credit, mode; // mode: 0 regular, 1 precharged, 2 pulled-in

  always @(posedge clk) begin
    bit busy, forced;
    if (!rst_n) begin
      now_t = 0; due_t = IVL; credit = 0; mode = 0;
      m_valid = 0; m_kind = 0; m_block = 0; m_event = 0;
      n_postpone = 0; n_forced = 0; n_prea = 0; n_floor = 0; n_late = 0; n_exit = 0;
    end else begin
      m_event = 0;
      busy = (idle != {NB{1'b1}});
      if (m_valid != 0) begin
        if (ready) begin
          m_valid = 0;
          if (m_kind == 0) begin
            m_block = 1; mode = 1; m_event = 5; n_prea++;
          end else begin
            m_block = 0; m_event = 10;
            if (mode == 2) credit = credit - 1;
            if (credit == -MPI) begin
              mode = 0; due_t += IVL; m_event = 7; n_floor++;
            end else if (now_t + DUR >= due_t + IVL) begin
              mode = 0; due_t += IVL; m_event = 8; n_late++;
            end else mode = 2;
          end
        end
      end else if (now_t >= due_t) begin
        if (mode == 0) begin
          forced = (credit == MPP);
          if (!forced && busy) begin
            credit++; due_t += IVL; m_event = 2; n_postpone++;
          end else begin
            m_valid = 1;
            m_kind  = (act != '0) ? 0 : 1;
            m_event = 4;
            if (forced) begin
              m_block = 1; m_event = 3; n_forced++;
              if (act == '0) mode = 1;
            end
          end
        end else if (mode == 1) begin
          m_valid = 1; m_kind = 1; m_event = 5;
        end else begin
          if (busy) begin
            mode = 0; due_t += IVL; m_event = 9; n_exit++;
          end else begin
            m_valid = 1; m_kind = 1; m_event = 9;
          end
        end
      end
      if (tick) now_t++;
    end
  end
endmodule

module tb_rf_allbank_sched;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [NB-1:0] bank_idle = '1;
  logic [NB-1:0] bank_act = '0;
  logic          chk_ready = 1'b0;

  logic a_valid, a_kind, a_block, a_pre, a_ref;
  logic z_valid, z_kind, z_block, z_pre, z_ref;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rf_allbank_sched #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bank_idle(bank_idle), .bank_act(bank_act),
    .chk_ready(chk_ready), .cmd_valid(a_valid), .cmd_kind(a_kind), .block_banks(a_block),
    .done_pre(a_pre), .done_ref(a_ref));

  rf_allbank_sched #(.NUM_BANKS(NB), .MAX_POSTPONE(0), .MAX_PULLIN(0)) dut_zero (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bank_idle(bank_idle), .bank_act(bank_act),
    .chk_ready(chk_ready), .cmd_valid(z_valid), .cmd_kind(z_kind), .block_banks(z_block),
    .done_pre(z_pre), .done_ref(z_ref));

  int av, ak, ab, aev, a_npp, a_nf, a_npre, a_nfl, a_nlate, a_nex;
  int zv, zk, zb, zev, z_npp, z_nf, z_npre, z_nfl, z_nlate, z_nex;

  tb_ref_model #(.NB(NB)) mdl_a (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle(bank_idle), .act(bank_act), .ready(chk_ready),
    .m_valid(av), .m_kind(ak), .m_block(ab), .m_event(aev), .n_postpone(a_npp), .n_forced(a_nf),
    .n_prea(a_npre), .n_floor(a_nfl), .n_late(a_nlate), .n_exit(a_nex));

  tb_ref_model #(.NB(NB), .MPP(0), .MPI(0)) mdl_z (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle(bank_idle), .act(bank_act), .ready(chk_ready),
    .m_valid(zv), .m_kind(zk), .m_block(zb), .m_event(zev), .n_postpone(z_npp), .n_forced(z_nf),
    .n_prea(z_npre), .n_floor(z_nfl), .n_late(z_nlate), .n_exit(z_nex));

  function automatic string tag_of(input int ev);
    case (ev)
      2: return "R2";
      3: return "R3";
      5: return "R5";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R4/R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic compare_all(input string who, input int ev,
                             input logic v, input logic k, input logic b, input logic p, input logic r,
                             input int ev_v, input int ev_k, input int ev_b, input bit z_inst);
    int got, exp_w;
    string req;
    int exp_p, exp_r;
    exp_p = (ev_v != 0 && chk_ready && ev_k == 0) ? 1 : 0;
    exp_r = (ev_v != 0 && chk_ready && ev_k == 1) ? 1 : 0;
    got   = {27'd0, v, (v ? k : 1'b0), b, p, r};
    exp_w = (ev_v << 4) | ((ev_v != 0 ? ev_k : 0) << 3) | (ev_b << 2) | (exp_p << 1) | exp_r;
    req = z_inst ? "R11" : tag_of(ev);
    check(req, {who, " {valid,kind,block,done_pre,done_ref}"}, got, exp_w);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      compare_all("main", aev, a_valid, a_kind, a_block, a_pre, a_ref, av, ak, ab, 1'b0);
      compare_all("zero", zev, z_valid, z_kind, z_block, z_pre, z_ref, zv, zk, zb, 1'b1);
    end
  end

  task automatic drive(input logic [NB-1:0] idl, input logic [NB-1:0] ac,
                       input logic rdy, input logic tk, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bank_idle = idl; bank_act = ac; chk_ready = rdy; tick = tk;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    drive('1, '0, 1'b0, 1'b0, 4);
    @(negedge clk); rst_n = 1'b1; chk_ready = 1'b1; tick = 1'b1;
    // R1: quiet outputs right after reset
    check("R1", "cmd_valid after reset", a_valid, 0);
    check("R1", "block after reset", a_block, 0);
    check("R1", "done pulses after reset", a_pre | a_ref, 0);
    // Idle rank: refreshes are pulled in down to the floor (R7)
    drive('1, '0, 1'b1, 1'b1, 80);
    // Busy with open rows: postpone, then forced precharge-all and refresh-all (R2, R3, R4, R5)
    drive(4'b1011, 4'b0100, 1'b1, 1'b1, 160);
    // Idle, checker stalls across the forced deadline: late exit (R6, R8)
    drive('1, '0, 1'b0, 1'b1, 60);
    drive('1, '0, 1'b1, 1'b1, 40);
    // Pulled-in run interrupted by work arriving (R9)
    for (int k = 0; k < 6; k++) begin
      drive('1, '0, 1'b1, 1'b1, 21);
      drive(4'b0111, '0, 1'b1, 1'b1, 2);
      drive(4'b0111, '0, 1'b1, 1'b1, 25);
    end
    // Sparse ticks and mixed patterns
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive((lfsr[3:2] == 2'b00) ? lfsr[7:4] : 4'b1111,
            lfsr[9] ? lfsr[13:10] & 4'b0011 : 4'b0000,
            lfsr[15:14] != 2'b00, lfsr[8] | lfsr[1], 1);
    end
    drive('1, '0, 1'b1, 1'b1, 4);
    // Reach checks: each path was taken by the stimulus
    check("R2", "postpones seen", int'(a_npp > 0), 1);
    check("R3", "forced refreshes seen", int'(a_nf > 0), 1);
    check("R5", "precharge-all accepted", int'(a_npre > 0), 1);
    check("R7", "floor exits seen", int'(a_nfl > 0), 1);
    check("R8", "late exits seen", int'(a_nlate > 0), 1);
    check("R9", "pulled-in exits seen", int'(a_nex > 0), 1);
    check("R11", "zero-limit instance postpones", z_npp, 0);
    check("R11", "zero-limit instance forced", int'(z_nf > 0), 1);
    summary();
  end

endmodule